// File: doc/BRIEF.md
# FIFO-Staged Synchronous Serial Transmitter

This block is the send side of a clocked serial link in which it is the clock master. It drives a serial clock and a data line. Bytes pass through three stages: a small first-in first-out store, a one-byte holding buffer, and a shift register that sends each byte least significant bit first. A fixed divider sets the bit rate: one bit lasts `2*DIV` system clocks.

Software loads bytes and then sets the transmit enable. A clear strobe empties the store and loads two settings in the same cycle: an interrupt threshold and an auto-stop option. The interrupt is a single-cycle pulse. It fires when a byte leaves the store and the number of bytes left equals the threshold. When auto-stop is armed, reaching the threshold stops the store from feeding the buffer. The bytes already in the buffer and the shifter go out, and then the channel goes quiet with the clock held high. Without auto-stop the channel stays armed and waits for more data.

The store is used only when its enable is set and the mode input selects half-duplex send. In any other mode a write goes straight into the holding buffer.

Top module: `sertx_fifo`

## Requirements
- R1: While `rst_n` is low and after its release, `sclk` and `sdo` are 1, and `busy`, `fifo_irq` and `overrun` are 0.
- R2: Each byte goes out least significant bit first, one bit per `2*DIV` clocks. In each bit period `sclk` is low for the first `DIV` clocks and high for the last `DIV` clocks. `sdo` changes only where `sclk` falls, and both lines rest at 1 when idle.
- R3: The store holds up to `DEPTH` (4) bytes. Bytes leave in the exact order they were written, pass through the buffer and the shifter, and go out back-to-back with no idle period between them.
- R4: When `cfg_fifo_en` and `cfg_hdx_tx` are not both 1, a write goes directly into the holding buffer. It is accepted only if the buffer is empty; otherwise it is dropped and `overrun` is set.
- R5: Bytes move from the store to the buffer, and from the buffer to the shifter, only while `txe` is 1. Bytes written while `txe` is 0 wait until it is set.
- R6: A `clr` pulse empties the store, loads `clr_level` and `clr_autostop`, and clears `overrun` and the stopped state. A write in the same cycle as `clr` is discarded.
- R7: `fifo_irq` is a one-clock pulse in the cycle after a byte moves from the store to the buffer and leaves the count equal to the 2-bit threshold. A threshold of 0 means the pulse follows the move of the last stored byte.
- R8: With auto-stop armed, no byte leaves the store after the threshold pulse, including bytes written later. The bytes in the buffer and the shifter are still sent. After that `busy` is 0 and `sclk` stays 1 until the next `clr`.
- R9: A write to a full store is dropped and sets a sticky `overrun`. A write in a cycle in which a byte leaves a full store is accepted.
- R10: No byte leaves the store while the holding buffer is occupied.
- R11: `busy` is 1 while a byte is shifting, and also while `txe` is 1 and the channel has not finished an auto-stop. If `txe` falls in the middle of a byte, that byte completes and then `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fifo_en | input | 1 | Enables the byte store |
| cfg_hdx_tx | input | 1 | Selects half-duplex send mode; the store needs it |
| txe | input | 1 | Transmit enable |
| clr | input | 1 | Clears the store and loads the settings |
| clr_level | input | 2 | Interrupt threshold loaded by `clr` |
| clr_autostop | input | 1 | Auto-stop option loaded by `clr` |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to write |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data, LSB first |
| fifo_irq | output | 1 | Threshold interrupt pulse |
| busy | output | 1 | Channel active flag |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
Two events can fall in the same clock: a byte leaving a full store for the buffer, and a new write arriving. The bench fills the store while `txe` is 0, then raises `txe` and writes in the same cycle. The write must be accepted without `overrun`, and all five bytes must come out in order. The threshold pulse may also fire twice, because the store returns to full after that cycle. A behavioural model built on queues predicts every output on every clock, so the exact cycle of the pulse and of each data edge is judged there.

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 4,
  parameter int DIV   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_fifo_en,
  input  logic       cfg_hdx_tx,
  input  logic       txe,
  input  logic       clr,
  input  logic [1:0] clr_level,
  input  logic       clr_autostop,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       sclk,
  output logic       sdo,
  output logic       fifo_irq,
  output logic       busy,
  output logic       overrun
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PER = 2 * DIV;
  localparam int DW  = (PER > 1) ? $clog2(PER) : 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          tb_v, sh_v;
  logic [7:0]    tb_d, sh_d;
  logic [2:0]    bit_cnt;
  logic [DW-1:0] div_cnt;
  logic [1:0]    level;
  logic          autostop, halted;

  logic active, period_end, last_bit, load_sh, pop, room, push, byp, drop, hit;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign active     = cfg_fifo_en & cfg_hdx_tx;
  assign period_end = sh_v && (div_cnt == DW'(PER - 1));
  assign last_bit   = period_end && (bit_cnt == 3'd7);
  assign load_sh    = tb_v && txe && (!sh_v || last_bit);
  assign pop        = active && txe && !halted && !clr && (cnt != '0) && !tb_v;
  assign room       = (cnt != CW'(DEPTH)) || pop;
  assign push       = wr_en && !clr && active && room;
  assign byp        = wr_en && !clr && !active && !tb_v;
  assign drop       = wr_en && !clr && (active ? !room : tb_v);
  assign hit        = pop && (cnt == CW'(level) + CW'(1));

  assign sclk = !(sh_v && (div_cnt < DW'(DIV)));
  assign sdo  = sh_v ? sh_d[0] : 1'b1;
  assign busy = sh_v | (txe & ~(halted & ~tb_v));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      cnt      <= '0;
      level    <= 2'd0;
      autostop <= 1'b0;
      halted   <= 1'b0;
      overrun  <= 1'b0;
      fifo_irq <= 1'b0;
    end else begin
      fifo_irq <= hit;
      if (clr) begin
        rd_ptr   <= '0;
        wr_ptr   <= '0;
        cnt      <= '0;
        level    <= clr_level;
        autostop <= clr_autostop;
        halted   <= 1'b0;
        overrun  <= 1'b0;
      end else begin
        if (pop)  rd_ptr <= adv(rd_ptr);
        if (push) wr_ptr <= adv(wr_ptr);
        cnt <= cnt + CW'(push) - CW'(pop);
        if (hit && autostop) halted <= 1'b1;
        if (drop) overrun <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_v <= 1'b0;
      tb_d <= 8'h00;
    end else if (pop) begin
      tb_v <= 1'b1;
      tb_d <= mem[rd_ptr];
    end else if (byp) begin
      tb_v <= 1'b1;
      tb_d <= wr_data;
    end else if (load_sh) begin
      tb_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_v    <= 1'b0;
      sh_d    <= 8'h00;
      bit_cnt <= 3'd0;
      div_cnt <= '0;
    end else if (load_sh) begin
      sh_v    <= 1'b1;
      sh_d    <= tb_d;
      bit_cnt <= 3'd0;
      div_cnt <= '0;
    end else if (sh_v) begin
      if (period_end) begin
        div_cnt <= '0;
        if (bit_cnt == 3'd7) sh_v <= 1'b0;
        else begin
          sh_d    <= sh_d >> 1;
          bit_cnt <= bit_cnt + 3'd1;
        end
      end else begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  assert_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_hold_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_v && !clr) |=> (cnt >= $past(cnt)));
  assert_irq_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_irq |=> !fifo_irq);
  assert_idle_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk && sdo));
  assert_sdo_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_v && $past(sh_v) && sclk && $past(sclk)) |-> $stable(sdo));
  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr) |=> overrun);
  assert_halt_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !clr) |=> (cnt >= $past(cnt)));
  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !sh_v && !tb_v) |-> (!busy && sclk));
endmodule

// File: tb/sertx_fifo_tb_top.sv
module sertx_fifo_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 4;
  localparam int DIV   = 2;
  localparam int BYTE_T = 16 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fen = 1'b0, hdx = 1'b0, txe = 1'b0, clr = 1'b0, as = 1'b0, wr = 1'b0;
  logic [1:0] lvl = 2'd0;
  logic [7:0] wd = 8'h00;
  logic sclk, sdo, irq, busy, ovr;

  int vec = 0, err = 0, irq_cnt = 0, rx_n = 0;
  logic [7:0] rxq[$];
  logic [7:0] rx_sh = 8'h00;
  bit prev_sclk = 1'b1, done = 1'b0;

  logic [7:0] mq[$];
  bit m_tbv = 0, m_shv = 0, m_as = 0, m_halt = 0, m_irq = 0, m_ovr = 0;
  logic [7:0] m_tbd = 0, m_sh = 0;
  int m_bit = 0, m_div = 0, m_lvl = 0;

  always #(CLK_P/2) clk = ~clk;

  sertx_fifo #(.DEPTH(DEPTH), .DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(fen), .cfg_hdx_tx(hdx), .txe(txe),
    .clr(clr), .clr_level(lvl), .clr_autostop(as), .wr_en(wr), .wr_data(wd),
    .sclk(sclk), .sdo(sdo), .fifo_irq(irq), .busy(busy), .overrun(ovr));

  task automatic chk(string req, string what, int act, int exp);
    vec++;
    if (act != exp) begin
      err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_tbv = 0; m_shv = 0; m_sh = 0; m_tbd = 0; m_bit = 0; m_div = 0;
      m_lvl = 0; m_as = 0; m_halt = 0; m_irq = 0; m_ovr = 0;
    end else begin
      int n0;
      bit act, last, ld, pp, hit, tbv0;
      n0 = mq.size();
      tbv0 = m_tbv;
      act = fen && hdx;
      last = m_shv && m_div == 2*DIV-1 && m_bit == 7;
      ld = m_tbv && txe && (!m_shv || last);
      pp = act && txe && !m_halt && !clr && n0 > 0 && !m_tbv;
      hit = pp && (n0 - 1 == m_lvl);
      m_irq = hit;
      if (ld) begin m_sh = m_tbd; m_shv = 1; m_bit = 0; m_div = 0; end
      else if (m_shv) begin
        if (m_div == 2*DIV-1) begin
          m_div = 0;
          if (m_bit == 7) m_shv = 0; else begin m_sh = m_sh >> 1; m_bit++; end
        end else m_div++;
      end
      if (pp) begin m_tbv = 1; m_tbd = mq.pop_front(); end
      else if (wr && !clr && !act && !tbv0) begin m_tbv = 1; m_tbd = wd; end
      else if (ld) m_tbv = 0;
      if (wr && !clr && !act && tbv0) m_ovr = 1;
      if (clr) begin mq.delete(); m_lvl = lvl; m_as = as; m_halt = 0; m_ovr = 0; end
      else if (wr && act) begin
        if (n0 < DEPTH || pp) mq.push_back(wd); else m_ovr = 1;
      end
      if (hit && m_as) m_halt = 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R2", "sclk", sclk, !(m_shv && m_div < DIV));
      chk("R2", "sdo", sdo, m_shv ? m_sh[0] : 1'b1);
      chk("R11", "busy", busy, m_shv || (txe && !(m_halt && !m_tbv)));
      chk("R7", "fifo_irq", irq, m_irq);
      chk("R9", "overrun", ovr, m_ovr);
      if (!prev_sclk && sclk) begin
        rx_sh = {sdo, rx_sh[7:1]};
        rx_n++;
        if (rx_n == 8) begin rxq.push_back(rx_sh); rx_n = 0; end
      end
      prev_sclk = sclk;
      if (irq) irq_cnt++;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic put(logic [7:0] b);
    wr = 1; wd = b; tick(); wr = 0;
  endtask

  task automatic clear(logic [1:0] l, logic a);
    clr = 1; lvl = l; as = a; tick(); clr = 0;
  endtask

  task automatic rx_is(string req, int idx, int exp);
    chk(req, $sformatf("rx byte %0d", idx), (rxq.size() > idx) ? int'(rxq[idx]) : -1, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err++;
    $display("FAIL R11 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R1", "sclk in reset", sclk, 1); chk("R1", "busy in reset", busy, 0);
    rst_n = 1; tick();
    chk("R1", "sdo", sdo, 1); chk("R1", "overrun", ovr, 0); chk("R1", "irq", irq, 0);

    // R3 R7 R8: level 0 with auto-stop, four bytes
    fen = 1; hdx = 1; clear(2'd0, 1'b1); rxq.delete(); irq_cnt = 0;
    put(8'hA1); put(8'hB2); put(8'hC3); put(8'hD4);
    chk("R5", "no send before txe", rxq.size(), 0);
    txe = 1; tick();
    for (int i = 0; i < 2000 && busy; i++) tick();
    chk("R8", "busy after stop", busy, 0);
    rx_is("R3", 0, 8'hA1); rx_is("R3", 1, 8'hB2); rx_is("R3", 2, 8'hC3); rx_is("R3", 3, 8'hD4);
    chk("R7", "irq pulses at level 0", irq_cnt, 1);
    put(8'h5E); tick(100);
    chk("R8", "no send after stop", rxq.size(), 4);
    txe = 0; tick();

    // R7 R11: level 2 without auto-stop stays armed
    clear(2'd2, 1'b0); rxq.delete(); irq_cnt = 0;
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    txe = 1; tick(4*BYTE_T + 20);
    chk("R7", "irq pulses at level 2", irq_cnt, 1);
    chk("R11", "armed busy", busy, 1);
    put(8'h77); tick(BYTE_T + 20);
    rx_is("R3", 3, 8'h44); rx_is("R11", 4, 8'h77);
    txe = 0; tick();
    chk("R11", "busy after txe low", busy, 0);

    // R9 R6: overrun on full store
    clear(2'd0, 1'b0); rxq.delete();
    put(8'h01); put(8'h02); put(8'h03); put(8'h04); put(8'h05);
    chk("R9", "overrun set", ovr, 1);
    tick(5);
    chk("R9", "overrun sticky", ovr, 1);
    txe = 1; tick(5*BYTE_T);
    chk("R9", "dropped byte not sent", rxq.size(), 4);
    rx_is("R9", 3, 8'h04);
    txe = 0; clear(2'd0, 1'b0);
    chk("R6", "overrun cleared", ovr, 0);

    // R6: clear empties and beats a same-cycle write
    rxq.delete(); irq_cnt = 0;
    put(8'h10); put(8'h20);
    clr = 1; lvl = 2'd1; as = 0; wr = 1; wd = 8'h30; tick(); clr = 0; wr = 0;
    txe = 1; tick(BYTE_T + 20);
    chk("R6", "nothing sent after clear", rxq.size(), 0);
    chk("R6", "no irq after clear", irq_cnt, 0);
    txe = 0; tick();

    // R9: pop and write in the same cycle on a full store
    clear(2'd3, 1'b0); rxq.delete(); irq_cnt = 0;
    put(8'h81); put(8'h82); put(8'h83); put(8'h84);
    txe = 1; wr = 1; wd = 8'h99; tick(); wr = 0;
    tick(5*BYTE_T + 20);
    chk("R9", "no overrun on pop+write", ovr, 0);
    rx_is("R3", 0, 8'h81); rx_is("R9", 4, 8'h99);
    chk("R7", "irq count level 3", irq_cnt, 2);
    txe = 0; tick();

    // R10: store held while buffer occupied
    clear(2'd0, 1'b0); rxq.delete();
    put(8'hE1); put(8'hE2); put(8'hE3); put(8'hE4);
    txe = 1; tick(10);
    put(8'hE5); put(8'hE6);
    chk("R10", "two slots free", ovr, 0);
    put(8'hE7);
    chk("R10", "store full again", ovr, 1);
    tick(6*BYTE_T + 20);
    chk("R3", "six bytes", rxq.size(), 6);
    rx_is("R10", 5, 8'hE6);
    txe = 0; tick();

    // R4: bypass when store not selected
    fen = 0; clear(2'd0, 1'b0); rxq.delete();
    put(8'h5A); put(8'h6B);
    chk("R4", "bypass overrun", ovr, 1);
    txe = 1; tick(BYTE_T + 20);
    chk("R4", "one bypass byte", rxq.size(), 1);
    rx_is("R4", 0, 8'h5A);
    txe = 0; fen = 1; tick();

    // R11 R5: txe dropped mid-byte
    clear(2'd0, 1'b0); rxq.delete();
    put(8'hC3); put(8'h3C); tick(20);
    chk("R5", "idle while txe low", busy, 0);
    txe = 1; tick(10); txe = 0; tick(BYTE_T + 10);
    chk("R11", "byte finished", rxq.size(), 1);
    rx_is("R11", 0, 8'hC3);
    chk("R11", "busy low", busy, 0);
    txe = 1; tick(BYTE_T + 20);
    rx_is("R5", 1, 8'h3C);
    txe = 0; tick(3);

    finish_run();
  end
endmodule